// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds an eight-bit output latch and derives, for every pin of a quasi-bidirectional I/O port, four drive enables:
- a pull-down;
- a strong pull-up that fires briefly;
- a weak pull-up that stays on;
- a medium pull-up controlled by the pin's own level.

No direction register exists. A pin whose latch bit is 1 drives a soft high that any external device may pull low, so the same pin serves as an output and as an input.

Software writes a byte through a write strobe. Each bit written as 1 fires a strong pull-up pulse of two clock cycles, which speeds the rising edge. While its latch bit is 1, a pin keeps its weak pull-up. The medium pull-up is added only while the pin actually reads high, so an external device holding the pin low fights only the weak source.

Resolved pin levels pass through a two-stage synchronizer. The synchronized levels feed the medium pull-up and the read path. A read select returns either the live synchronized pin levels or the latch contents, and the latch contents support read-modify-write. The block clocks from the oscillator clock and has an asynchronous active-low reset whose release is synchronized internally.

Top module: `qbd_port_ctrl`

## Requirements
- R1: A pin's pull-down enable is 1 exactly when its latch bit is 0. A write takes effect on the pull-down enable in the cycle after the write edge.
- R2: Writing 1 to a latch bit asserts that pin's strong pull-up enable for exactly two clock cycles, starting right after the write edge. The enable is then 0.
- R3: A pin's weak pull-up enable equals its latch bit and holds steady while no write occurs.
- R4: A pin's medium pull-up enable is 1 only when its latch bit is 1 and its synchronized pin level is 1. The synchronized level is the pin input as sampled two clock edges earlier.
- R5: After reset every latch bit is 1, and no strong pull-up pulse is generated by reset or by its release.
- R6: With read select 0, read data is the synchronized pin level. It has a latency of two edges and follows every change; it never holds a stale value.
- R7: With read select 1, read data is the latch contents.
- R8: Writing 1 to a bit that already holds 1 restarts that bit's two-cycle strong pulse.
- R9: Writing 0 to a bit ends any strong pulse on it from the next cycle on.
- R10: On any pin, the pull-down enable is never 1 together with the strong pull-up enable or with the medium pull-up enable.
- R11: A pin with latch bit 1 that an external device holds low reads back 0. Once the level is synchronized, only its weak pull-up is enabled on that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Byte written to the latch |
| rd_sel_latch | input | 1 | 0 selects pin levels for read data, 1 selects latch |
| pin_in | input | 8 | Resolved pin levels, asynchronous |
| rd_data | output | 8 | Read data |
| pull_down_en | output | 8 | Per-pin pull-down enable |
| strong_up_en | output | 8 | Per-pin brief strong pull-up enable |
| weak_up_en | output | 8 | Per-pin permanent weak pull-up enable |
| mid_up_en | output | 8 | Per-pin level-following medium pull-up enable |

## Verification
The assertions check several properties on every cycle:
- that pull-down never overlaps the strong or medium pull-up;
- that each write sets the pull-down enable and starts or cancels the strong pulses as written;
- that no pulse outlives two write-free cycles;
- that the medium pull-up and the pin read path track the pin input delayed by two edges.

Only the bench scenarios show the rest. These are:
- the exact pulse length;
- retriggering by a repeated write of 1;
- the absence of a pulse at reset release;
- an external device overriding a high pin through a modelled wired node, with the read data recovering once the device lets go.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef enum logic {
    RD_SRC_PIN   = 1'b0,
    RD_SRC_LATCH = 1'b1
  } rd_src_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/qbd_rst_sync.sv
module qbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/qbd_pin_sync.sv
module qbd_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = pin_async;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/qbd_bit_drive.sv
module qbd_bit_drive #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic pin_s,
  output logic latch_q,
  output logic pd_en,
  output logic strong_en,
  output logic weak_en,
  output logic mid_en
);
  localparam int CW = qbd_pkg::cnt_width(PULSE_CYCLES);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYCLES);

  logic          latch_d;
  logic          latch_ce;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ce;

  // next state: a write loads latch and (re)arms or clears the pulse
  always_comb begin
    latch_ce = wr_en;
    latch_d  = wr_bit;
    cnt_ce   = wr_en || (cnt_q != '0);
    if (wr_en) cnt_d = wr_bit ? PULSE_LD : '0;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b1;
    else if (latch_ce) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign pd_en     = ~latch_q;
  assign strong_en = (cnt_q != '0);
  assign weak_en   = latch_q;
  assign mid_en    = latch_q & pin_s;
endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_sel_latch,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pull_down_en,
  output logic [WIDTH-1:0] strong_up_en,
  output logic [WIDTH-1:0] weak_up_en,
  output logic [WIDTH-1:0] mid_up_en
);
  import qbd_pkg::*;

  logic             rst_n_core;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] latch_bits;
  rd_src_e          rd_src;

  qbd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_core)
  );

  qbd_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_n_core),
    .pin_async (pin_in),
    .pin_sync  (pin_s)
  );

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      qbd_bit_drive #(.PULSE_CYCLES(PULSE_CYCLES)) u_bit (
        .clk       (clk),
        .rst_n     (rst_n_core),
        .wr_en     (wr_en),
        .wr_bit    (wr_data[b]),
        .pin_s     (pin_s[b]),
        .latch_q   (latch_bits[b]),
        .pd_en     (pull_down_en[b]),
        .strong_en (strong_up_en[b]),
        .weak_en   (weak_up_en[b]),
        .mid_en    (mid_up_en[b])
      );
    end
  endgenerate

  always_comb begin
    rd_src = rd_src_e'(rd_sel_latch);
    case (rd_src)
      RD_SRC_LATCH: rd_data = latch_bits;
      default:      rd_data = pin_s;
    endcase
  end
endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_sel_latch,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] pull_down_en,
  input logic [WIDTH-1:0] strong_up_en,
  input logic [WIDTH-1:0] weak_up_en,
  input logic [WIDTH-1:0] mid_up_en
);
  // checks start once internal reset and synchronizer have settled
  logic [2:0] age_q;
  logic       chk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd6)  age_q <= age_q + 3'd1;
  end
  assign chk_on = (age_q == 3'd6);

  assert_pd_write_R1: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    wr_en |=> pull_down_en == ~$past(wr_data));

  assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    wr_en |=> (strong_up_en & $past(wr_data)) == $past(wr_data));

  assert_pulse_end_R2: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    (!$past(wr_en) && !$past(wr_en, 2)) |-> strong_up_en == '0);

  assert_weak_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    !wr_en |=> $stable(weak_up_en));

  assert_mid_follow_R4: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    mid_up_en == (weak_up_en & $past(pin_in, 2)));

  assert_pin_read_R6: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    !rd_sel_latch |-> rd_data == $past(pin_in, 2));

  assert_latch_read_R7: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    rd_sel_latch |-> rd_data == weak_up_en);

  assert_zero_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n || !chk_on)
    wr_en |=> (strong_up_en & ~$past(wr_data)) == '0);

  assert_no_strong_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_up_en & pull_down_en) == '0);

  assert_no_mid_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_up_en & pull_down_en) == '0);
endmodule

bind qbd_port_ctrl qbd_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_sel_latch (rd_sel_latch),
  .pin_in       (pin_in),
  .rd_data      (rd_data),
  .pull_down_en (pull_down_en),
  .strong_up_en (strong_up_en),
  .weak_up_en   (weak_up_en),
  .mid_up_en    (mid_up_en)
);

// File: tb/tb_qbd_port_ctrl.sv
`timescale 1ns/1ps
module tb_qbd_port_ctrl;
  localparam int W = 8;
  localparam int NV = 8;
  // each entry: {latch byte written, external pull-low mask}
  localparam logic [15:0] VEC [NV] = '{
    16'hFF_00, 16'h00_00, 16'hA5_00, 16'hFF_3C,
    16'h0F_F0, 16'hF0_F0, 16'h81_7E, 16'hFF_FF
  };

  logic clk;
  logic rst_n, wr_en, rd_sel_latch;
  logic [W-1:0] wr_data, ext_low, pin;
  logic [W-1:0] rd_data, pull_down_en, strong_up_en, weak_up_en, mid_up_en;
  int n_run, n_fail;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // wired node per pin: external low wins, then pull-down, then any pull-up
  always_comb begin
    for (int i = 0; i < W; i++)
      pin[i] = ext_low[i] ? 1'b0 : pull_down_en[i] ? 1'b0 :
               (strong_up_en[i] | weak_up_en[i] | mid_up_en[i]);
  end

  qbd_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel_latch(rd_sel_latch), .pin_in(pin), .rd_data(rd_data),
    .pull_down_en(pull_down_en), .strong_up_en(strong_up_en),
    .weak_up_en(weak_up_en), .mid_up_en(mid_up_en)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_pin(input string req, input logic [W-1:0] exp);
    rd_sel_latch = 1'b0; #0.5; check(req, rd_data, exp);
  endtask

  task automatic rd_latch(input string req, input logic [W-1:0] exp);
    rd_sel_latch = 1'b1; #0.5; check(req, rd_data, exp); rd_sel_latch = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_sel_latch = 1'b0; ext_low = '0;
    n_run = 0; n_fail = 0; done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    // R5: no pulse during or after release
    for (int c = 0; c < 5; c++) begin
      tick();
      check("R5 strong after release", strong_up_en, 8'h00);
    end
    rd_latch("R5 latch reset", 8'hFF);
    check("R5 pull-down reset", pull_down_en, 8'h00);
    check("R3 weak reset", weak_up_en, 8'hFF);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] d, e;
      d = VEC[v][15:8]; e = VEC[v][7:0];
      ext_low = e;
      wr(d);
      tick(3);
      check("R1 pull-down", pull_down_en, ~d);
      check("R3 weak", weak_up_en, d);
      check("R4 mid", mid_up_en, d & ~e);
      check("R2 strong settled", strong_up_en, 8'h00);
      rd_pin("R6 pin read", d & ~e);
      rd_latch("R7 latch read", d);
    end
    ext_low = '0;

    // R2 pulse length and R10 from all-zero latch
    wr(8'h00); tick(2);
    wr(8'h0F);
    check("R2 pulse cycle 1", strong_up_en, 8'h0F);
    check("R10 strong vs pull-down", strong_up_en & pull_down_en, 8'h00);
    tick();
    check("R2 pulse cycle 2", strong_up_en, 8'h0F);
    tick();
    check("R2 pulse ended", strong_up_en, 8'h00);

    // R8 retrigger
    wr(8'h00); tick(2);
    wr(8'h01);
    wr(8'h01);
    check("R8 retrigger cycle 1", strong_up_en, 8'h01);
    tick();
    check("R8 retrigger extends", strong_up_en, 8'h01);
    tick();
    check("R8 retrigger ended", strong_up_en, 8'h00);

    // R9 cancel by zero
    wr(8'h01);
    wr(8'h00);
    check("R9 cancel", strong_up_en, 8'h00);
    check("R10 mid vs pull-down", mid_up_en & pull_down_en, 8'h00);

    // R11 external override of a high pin, and R6 no hold
    wr(8'hFF); tick(3);
    ext_low = 8'h80;
    tick(3);
    rd_pin("R11 override read", 8'h7F);
    check("R11 only weak on pin7 (mid)", mid_up_en, 8'h7F);
    check("R11 only weak on pin7 (weak)", weak_up_en, 8'hFF);
    check("R11 no pull-down", pull_down_en, 8'h00);
    ext_low = 8'h55; tick(3);
    rd_pin("R6 pattern", 8'hAA);
    ext_low = 8'h00;
    tick();
    rd_pin("R6 latency edge 1", 8'hAA);
    tick();
    rd_pin("R6 follows release", 8'hFF);
    tick(2);
    finish_run();
  end
endmodule